// File: doc/BRIEF.md
# MSI capability register file

This block holds the message-signalled-interrupt capability structure of a PCI function. It sits on the function's configuration-space path and looks at every dword read or write, together with its byte enables. Only the bytes that fall inside the capability window are decoded. Writes are merged through a write mask for each field. Inside the window the block keeps the control word, the message address, the message data, and the mask and pending words for each vector. It returns the read value on the same cycle as the request.

Two elaboration options change the layout. One adds a 64-bit address; the other adds masking for each vector. With the 64-bit address, the data, mask and pending words each move up by four bytes. Whenever a write touches the capability while interrupts are enabled, the block does three things. It limits the requested vector count to the capable count. It drops pending bits for vectors beyond the enabled count. It emits a one-cycle pulse to withdraw the legacy wire interrupt, and a matching update strobe that tells the interrupt generator to re-examine masked and pending vectors. The generator also reads the live address, data, enable, vector count, mask and pending values from the outputs. It sets and clears pending bits through two vector inputs.

Top module: `msi_cap_regs`

## Requirements
- R1: After synchronous reset the enable bit, the enabled vector count, both address words, the data word, the mask word and the pending word are all zero. The read-only control fields still show their parameter values: capable log2 count at control bits 3:1, 64-bit flag at bit 7, masking flag at bit 8. The 16-bit control word occupies bits 31:16 of the capability's first dword.
- R2: A control write (byte lane 2 of the first dword) changes only the enable bit (control bit 0) and the 3-bit enabled log2 count (control bits 6:4). All other control bits ignore written values.
- R3: The low address word is at capability offset 4, and its bits 1:0 always read zero. With the 64-bit option, the high address word at offset 8 is fully writable.
- R4: The message data is a writable 16-bit field. It sits at offset 0x0C with the 64-bit option and at 0x08 without it. Bits 31:16 of its dword read zero.
- R5: The mask word is at offset 0x10 with the 64-bit option and at 0x0C without it. Only bits 0 to N-1 are writable, where N = 2^CAP_LOG2.
- R6: The pending word is at offset 0x14 with the 64-bit option and at 0x10 without it. Software writes do not change it. A bit set in `pend_set` sets it; a bit set in `pend_clr` clears it.
- R7: On a write that overlaps the capability and leaves the enable bit at 1, an enabled log2 count above CAP_LOG2 is replaced by CAP_LOG2. While the enable bit is 0, the written count is kept as written.
- R8: On such an enabled write, pending bits at positions of 2^(enabled log2 count) or above are cleared. The limited count is used.
- R9: `intx_deassert` and `cfg_upd` are high for exactly the one cycle after a write that overlaps the capability and leaves the enable bit at 1. They stay low for writes made while disabled and for writes outside the window.
- R10: Writes whose enabled bytes all lie outside the window change nothing. Reads return zero in any byte lane that is outside the window, not enabled, or unimplemented (capability id and next-pointer bytes included), and return zero when `cfg_rd` is low.
- R11: `msg_addr`, `msg_data`, `msi_en`, `vec_log2`, `vec_mask` and `vec_pend` always equal the register contents that a configuration read would return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high functional reset |
| cfg_addr | input | CFG_AW (6) | Dword address within configuration space |
| cfg_be | input | 4 | Byte enables for the access |
| cfg_wr | input | 1 | Write request, one cycle |
| cfg_rd | input | 1 | Read request |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, combinational |
| pend_set | input | 2^CAP_LOG2 (8) | Pending bits to set, from the interrupt generator |
| pend_clr | input | 2^CAP_LOG2 (8) | Pending bits to clear, from the interrupt generator |
| msi_en | output | 1 | Enable bit |
| vec_log2 | output | 3 | Enabled log2 vector count |
| msg_addr | output | 64 | Message address (upper half zero without the 64-bit option) |
| msg_data | output | 16 | Message data |
| vec_mask | output | 2^CAP_LOG2 (8) | Mask bits for each vector |
| vec_pend | output | 2^CAP_LOG2 (8) | Pending bits for each vector |
| intx_deassert | output | 1 | Pulse: withdraw the legacy wire interrupt |
| cfg_upd | output | 1 | Pulse: capability written while enabled |

## Verification
Some properties are checked on every cycle. After each strobe, the vector count is within the capable count and the enable bit is set. Pending bits above the new count are gone the cycle after an enabled write. Pending bits only rise where `pend_set` asked. The enable bit, the mask and the message fields move only on a write that reaches their field. Other behaviours need the bench's scenarios: the exact placement of each field in the 64-bit, masked layout, the per-lane read and write masks, the counter example of an illegal count kept while disabled, and writes next to the window that must leave everything untouched.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

    // Which register a capability dword maps to.
    typedef enum logic [2:0] {
        FLD_NONE,
        FLD_CTRL,
        FLD_ALO,
        FLD_AHI,
        FLD_DATA,
        FLD_MASK,
        FLD_PEND
    } fld_e;

    // A decoded write, lanes already limited to the window.
    typedef struct packed {
        logic        hit;
        fld_e        fld;
        logic [3:0]  be;
        logic [31:0] data;
    } wreq_t;

    // Capability length in bytes for each layout option.
    function automatic int cap_len(bit a64, bit pvm);
        if (pvm) return a64 ? 24 : 20;
        return a64 ? 14 : 10;
    endfunction

    // Dword index inside the capability -> field.
    function automatic fld_e fld_of(logic [2:0] rel, bit a64, bit pvm);
        fld_e f;
        case (rel)
            3'd0:    f = FLD_CTRL;
            3'd1:    f = FLD_ALO;
            3'd2:    f = a64 ? FLD_AHI : FLD_DATA;
            3'd3:    f = a64 ? FLD_DATA : (pvm ? FLD_MASK : FLD_NONE);
            3'd4:    f = pvm ? (a64 ? FLD_MASK : FLD_PEND) : FLD_NONE;
            3'd5:    f = (pvm && a64) ? FLD_PEND : FLD_NONE;
            default: f = FLD_NONE;
        endcase
        return f;
    endfunction

    // Ones in the low 2^lg bit positions.
    function automatic logic [31:0] vec_span(logic [2:0] lg);
        if (lg >= 3'd5) return 32'hFFFF_FFFF;
        return (32'd1 << (32'd1 << lg)) - 32'd1;
    endfunction

    // Byte-lane merge: enabled lanes take new data where wm is set.
    function automatic logic [31:0] merge_be(logic [31:0] old_v, logic [31:0] nv,
                                             logic [3:0] be, logic [31:0] wm);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) begin
            r[8*b +: 8] = be[b] ? ((old_v[8*b +: 8] & ~wm[8*b +: 8]) |
                                   (nv[8*b +: 8] & wm[8*b +: 8]))
                                : old_v[8*b +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/msi_cap_decode.sv
module msi_cap_decode
    import msi_cap_pkg::*;
#(
    parameter int CAP_BASE = 8'h50,
    parameter bit ADDR64   = 1'b1,
    parameter bit PVM      = 1'b1,
    parameter int CFG_AW   = 6
) (
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic              cfg_wr,
    input  logic [31:0]       cfg_wdata,
    output wreq_t             wreq,
    output fld_e              rd_fld,
    output logic [3:0]        rd_lanes
);
    localparam int LEN = cap_len(ADDR64, PVM);
    localparam int WIN_LO = CAP_BASE;
    localparam int WIN_HI = CAP_BASE + LEN;
    localparam logic [CFG_AW-1:0] BASE_DW = CFG_AW'(CAP_BASE / 4);

    logic [3:0] in_win;

    for (genvar b = 0; b < 4; b++) begin : g_lane
        logic [CFG_AW+1:0] baddr;
        assign baddr     = {cfg_addr, 2'(b)};
        assign in_win[b] = (int'(baddr) >= WIN_LO) && (int'(baddr) < WIN_HI);
    end

    logic [CFG_AW-1:0] rel_full;
    logic [2:0]        rel;
    fld_e              fld;

    assign rel_full = cfg_addr - BASE_DW;
    assign rel      = rel_full[2:0];
    assign fld      = (|in_win) ? fld_of(rel, ADDR64, PVM) : FLD_NONE;

    logic unused_rel;
    assign unused_rel = ^rel_full;

    assign wreq.hit  = cfg_wr && (|(cfg_be & in_win));
    assign wreq.fld  = fld;
    assign wreq.be   = cfg_be & in_win;
    assign wreq.data = cfg_wdata;
    assign rd_fld    = fld;
    assign rd_lanes  = in_win;

endmodule

// File: rtl/msi_cap_ctrl.sv
module msi_cap_ctrl
    import msi_cap_pkg::*;
#(
    parameter int CAP_LOG2 = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  wreq_t      wreq,
    output logic       en,
    output logic [2:0] qsize,
    output logic [2:0] qsize_nxt,
    output logic       upd_nxt,
    output logic       intx_deassert,
    output logic       cfg_upd
);
    localparam logic [2:0] CAPLG = 3'(CAP_LOG2);

    logic       ctl_wr;
    logic       en_w;
    logic [2:0] qs_w;

    // Control word is dword bits 31:16; writable bits live in lane 2.
    assign ctl_wr = wreq.hit && (wreq.fld == FLD_CTRL) && wreq.be[2];

    always_comb begin
        en_w = en;
        qs_w = qsize;
        if (ctl_wr) begin
            en_w = wreq.data[16];
            qs_w = wreq.data[22:20];
        end
        upd_nxt   = wreq.hit && en_w;
        qsize_nxt = (upd_nxt && (qs_w > CAPLG)) ? CAPLG : qs_w;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en            <= 1'b0;
            qsize         <= 3'd0;
            intx_deassert <= 1'b0;
            cfg_upd       <= 1'b0;
        end else begin
            en            <= en_w;
            qsize         <= qsize_nxt;
            intx_deassert <= upd_nxt;
            cfg_upd       <= upd_nxt;
        end
    end

    logic unused_ctl;
    assign unused_ctl = ^{wreq.data[31:23], wreq.data[19:17], wreq.data[15:0],
                          wreq.be[3], wreq.be[1:0]};

    a_r1_reset_off: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!en && qsize == 3'd0));
    a_r2_en_write_only: assert property (@(posedge clk) disable iff (rst)
        !$past(ctl_wr) |-> $stable(en));
    a_r7_count_limited: assert property (@(posedge clk) disable iff (rst)
        cfg_upd |-> (qsize <= CAPLG));
    a_r9_upd_enabled: assert property (@(posedge clk) disable iff (rst)
        cfg_upd |-> en);

endmodule

// File: rtl/msi_cap_msg.sv
module msi_cap_msg
    import msi_cap_pkg::*;
#(
    parameter bit ADDR64 = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  wreq_t       wreq,
    output logic [31:2] addr_lo,
    output logic [31:0] addr_hi,
    output logic [15:0] data
);
    logic [31:0] alo_m;
    logic [31:0] dat_m;

    assign alo_m = merge_be({addr_lo, 2'b00}, wreq.data, wreq.be, 32'hFFFF_FFFC);
    assign dat_m = merge_be({16'h0, data}, wreq.data, wreq.be, 32'h0000_FFFF);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_lo <= '0;
            data    <= '0;
        end else begin
            if (wreq.hit && wreq.fld == FLD_ALO)  addr_lo <= alo_m[31:2];
            if (wreq.hit && wreq.fld == FLD_DATA) data    <= dat_m[15:0];
        end
    end

    logic unused_msg;
    assign unused_msg = ^{alo_m[1:0], dat_m[31:16]};

    if (ADDR64) begin : g_hi
        logic [31:0] ahi_m;
        assign ahi_m = merge_be(addr_hi, wreq.data, wreq.be, 32'hFFFF_FFFF);
        always_ff @(posedge clk) begin
            if (rst)                                   addr_hi <= '0;
            else if (wreq.hit && wreq.fld == FLD_AHI)  addr_hi <= ahi_m;
        end
    end else begin : g_nohi
        assign addr_hi = '0;
    end

    a_r10_msg_untouched: assert property (@(posedge clk) disable iff (rst)
        !$past(wreq.hit) |-> ($stable(addr_lo) && $stable(data) && $stable(addr_hi)));

endmodule

// File: rtl/msi_cap_vec.sv
module msi_cap_vec
    import msi_cap_pkg::*;
#(
    parameter int CAP_LOG2 = 3,
    parameter bit PVM      = 1'b1,
    localparam int NVEC    = 1 << CAP_LOG2
) (
    input  logic            clk,
    input  logic            rst,
    input  wreq_t           wreq,
    input  logic            trim,
    input  logic [2:0]      trim_lg,
    input  logic [NVEC-1:0] pend_set,
    input  logic [NVEC-1:0] pend_clr,
    output logic [NVEC-1:0] mask,
    output logic [NVEC-1:0] pend
);
    localparam logic [31:0] MASK_WM = vec_span(3'(CAP_LOG2));

    if (PVM) begin : g_pvm
        logic [31:0]     mask_m;
        logic [31:0]     span;
        logic [NVEC-1:0] span_lo;
        logic [NVEC-1:0] pend_n;

        assign mask_m  = merge_be(32'(mask), wreq.data, wreq.be, MASK_WM);
        assign span    = vec_span(trim_lg);
        assign span_lo = span[NVEC-1:0];

        always_comb begin
            pend_n = (pend & ~pend_clr) | pend_set;
            if (trim) pend_n = pend_n & span_lo;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                mask <= '0;
                pend <= '0;
            end else begin
                if (wreq.hit && wreq.fld == FLD_MASK) mask <= mask_m[NVEC-1:0];
                pend <= pend_n;
            end
        end

        logic unused_vec;
        assign unused_vec = ^{mask_m, span};

        a_r8_trim_high: assert property (@(posedge clk) disable iff (rst)
            $past(trim) |-> ((pend & ~$past(span_lo)) == '0));
        a_r6_rise_by_set: assert property (@(posedge clk) disable iff (rst)
            ((pend & ~$past(pend) & ~$past(pend_set)) == '0));
        a_r5_mask_by_write: assert property (@(posedge clk) disable iff (rst)
            !$past(wreq.hit && wreq.fld == FLD_MASK) |-> $stable(mask));
    end else begin : g_nopvm
        assign mask = '0;
        assign pend = '0;
        logic unused_vec;
        assign unused_vec = ^{clk, rst, wreq, trim, trim_lg, pend_set, pend_clr};
    end

endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
    import msi_cap_pkg::*;
#(
    parameter int CAP_BASE = 8'h50,
    parameter int CAP_LOG2 = 3,
    parameter bit ADDR64   = 1'b1,
    parameter bit PVM      = 1'b1,
    parameter int CFG_AW   = 6,
    localparam int NVEC    = 1 << CAP_LOG2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [NVEC-1:0]   pend_set,
    input  logic [NVEC-1:0]   pend_clr,
    output logic              msi_en,
    output logic [2:0]        vec_log2,
    output logic [63:0]       msg_addr,
    output logic [15:0]       msg_data,
    output logic [NVEC-1:0]   vec_mask,
    output logic [NVEC-1:0]   vec_pend,
    output logic              intx_deassert,
    output logic              cfg_upd
);
    localparam logic [2:0] CAPLG = 3'(CAP_LOG2);

    wreq_t       wreq;
    fld_e        rd_fld;
    logic [3:0]  rd_lanes;
    logic [2:0]  qsize_nxt;
    logic        upd_nxt;
    logic [31:2] addr_lo;
    logic [31:0] addr_hi;
    logic [31:0] rd_raw;

    msi_cap_decode #(
        .CAP_BASE(CAP_BASE), .ADDR64(ADDR64), .PVM(PVM), .CFG_AW(CFG_AW)
    ) u_dec (
        .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .wreq(wreq), .rd_fld(rd_fld), .rd_lanes(rd_lanes)
    );

    msi_cap_ctrl #(.CAP_LOG2(CAP_LOG2)) u_ctrl (
        .clk(clk), .rst(rst), .wreq(wreq),
        .en(msi_en), .qsize(vec_log2), .qsize_nxt(qsize_nxt), .upd_nxt(upd_nxt),
        .intx_deassert(intx_deassert), .cfg_upd(cfg_upd)
    );

    msi_cap_msg #(.ADDR64(ADDR64)) u_msg (
        .clk(clk), .rst(rst), .wreq(wreq),
        .addr_lo(addr_lo), .addr_hi(addr_hi), .data(msg_data)
    );

    msi_cap_vec #(.CAP_LOG2(CAP_LOG2), .PVM(PVM)) u_vec (
        .clk(clk), .rst(rst), .wreq(wreq),
        .trim(upd_nxt), .trim_lg(qsize_nxt),
        .pend_set(pend_set), .pend_clr(pend_clr),
        .mask(vec_mask), .pend(vec_pend)
    );

    assign msg_addr = {addr_hi, addr_lo, 2'b00};

    always_comb begin
        case (rd_fld)
            FLD_CTRL: rd_raw = {7'b0, PVM, ADDR64, vec_log2, CAPLG, msi_en, 16'h0};
            FLD_ALO:  rd_raw = {addr_lo, 2'b00};
            FLD_AHI:  rd_raw = addr_hi;
            FLD_DATA: rd_raw = {16'h0, msg_data};
            FLD_MASK: rd_raw = 32'(vec_mask);
            FLD_PEND: rd_raw = 32'(vec_pend);
            default:  rd_raw = '0;
        endcase
        for (int b = 0; b < 4; b++) begin
            cfg_rdata[8*b +: 8] = (cfg_rd && rd_lanes[b] && cfg_be[b]) ? rd_raw[8*b +: 8] : 8'h00;
        end
    end

endmodule

// File: tb/msi_cap_regs_test.sv
`timescale 1ns/1ps
module msi_cap_regs_test;
    localparam int CAP_BASE = 8'h50;
    localparam int BASE_DW  = CAP_BASE / 4;
    localparam int NVEC     = 8;
    localparam int CAPLG    = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  cfg_addr;
    logic [3:0]  cfg_be;
    logic        cfg_wr, cfg_rd;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic [7:0]  pend_set, pend_clr;
    logic        msi_en;
    logic [2:0]  vec_log2;
    logic [63:0] msg_addr;
    logic [15:0] msg_data;
    logic [7:0]  vec_mask, vec_pend;
    logic        intx_deassert, cfg_upd;

    msi_cap_regs uut (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wr(cfg_wr),
        .cfg_rd(cfg_rd), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .pend_set(pend_set), .pend_clr(pend_clr), .msi_en(msi_en), .vec_log2(vec_log2),
        .msg_addr(msg_addr), .msg_data(msg_data), .vec_mask(vec_mask), .vec_pend(vec_pend),
        .intx_deassert(intx_deassert), .cfg_upd(cfg_upd)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Model of the register contents, built from the requirements.
    bit        m_en;
    bit [2:0]  m_qs;
    bit [31:0] m_alo, m_ahi;
    bit [15:0] m_data;
    bit [7:0]  m_mask, m_pend;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit [31:0] m_dword(int rel);
        case (rel)
            0: return {7'b0, 1'b1, 1'b1, m_qs, 3'(CAPLG), m_en, 16'h0};
            1: return m_alo;
            2: return m_ahi;
            3: return {16'h0, m_data};
            4: return {24'h0, m_mask};
            5: return {24'h0, m_pend};
            default: return 32'h0;
        endcase
    endfunction

    function automatic bit [31:0] lane_merge(bit [31:0] o, bit [31:0] n, bit [3:0] be, bit [31:0] wm);
        bit [31:0] r = o;
        for (int b = 0; b < 4; b++)
            if (be[b]) r[8*b +: 8] = (o[8*b +: 8] & ~wm[8*b +: 8]) | (n[8*b +: 8] & wm[8*b +: 8]);
        return r;
    endfunction

    task automatic do_write(int dw, bit [3:0] be, bit [31:0] d, string req);
        int  rel = dw - BASE_DW;
        bit  hit = (be != 0) && rel >= 0 && rel <= 5;
        bit  e_upd;
        @(negedge clk);
        cfg_addr = 6'(dw); cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
        if (hit) begin
            case (rel)
                0: if (be[2]) begin m_en = d[16]; m_qs = d[22:20]; end
                1: m_alo  = lane_merge(m_alo, d, be, 32'hFFFF_FFFC);
                2: m_ahi  = lane_merge(m_ahi, d, be, 32'hFFFF_FFFF);
                3: m_data = 16'(lane_merge({16'h0, m_data}, d, be, 32'h0000_FFFF));
                4: m_mask = 8'(lane_merge({24'h0, m_mask}, d, be, 32'h0000_00FF));
                default: ;
            endcase
        end
        e_upd = hit && m_en;
        if (e_upd) begin
            if (m_qs > 3'(CAPLG)) m_qs = 3'(CAPLG);
            m_pend = m_pend & 8'((9'd1 << (4'd1 << m_qs)) - 9'd1);
        end
        @(negedge clk);
        cfg_wr = 1'b0;
        #1;
        chk("R9", "intx_deassert", {63'h0, intx_deassert}, {63'h0, e_upd});
        chk("R9", "cfg_upd", {63'h0, cfg_upd}, {63'h0, e_upd});
        if (req != "") chk(req, "write strobe", {63'h0, cfg_upd}, {63'h0, e_upd});
    endtask

    task automatic do_pend(bit [7:0] s, bit [7:0] c);
        @(negedge clk);
        pend_set = s; pend_clr = c;
        m_pend = (m_pend & ~c) | s;
        @(negedge clk);
        pend_set = '0; pend_clr = '0;
    endtask

    task automatic rd(int dw, bit [3:0] be, output logic [31:0] v);
        @(negedge clk);
        cfg_addr = 6'(dw); cfg_be = be; cfg_rd = 1'b1;
        #1 v = cfg_rdata;
        cfg_rd = 1'b0;
    endtask

    task automatic check_all(string req);
        logic [31:0] v;
        for (int r = 0; r < 6; r++) begin
            rd(BASE_DW + r, 4'hF, v);
            chk(req, $sformatf("dword %0d", r), {32'h0, v}, {32'h0, m_dword(r)});
        end
        chk("R11", "msi_en", {63'h0, msi_en}, {63'h0, m_en});
        chk("R11", "vec_log2", {61'h0, vec_log2}, {61'h0, m_qs});
        chk("R11", "msg_addr", msg_addr, {m_ahi, m_alo});
        chk("R11", "msg_data", {48'h0, msg_data}, {48'h0, m_data});
        chk("R11", "vec_mask", {56'h0, vec_mask}, {56'h0, m_mask});
        chk("R11", "vec_pend", {56'h0, vec_pend}, {56'h0, m_pend});
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5EED_0A11));
        rst = 1'b1; cfg_addr = '0; cfg_be = '0; cfg_wr = 1'b0; cfg_rd = 1'b0;
        cfg_wdata = '0; pend_set = '0; pend_clr = '0;
        m_en = 0; m_qs = 0; m_alo = 0; m_ahi = 0; m_data = 0; m_mask = 0; m_pend = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset contents and read-only control fields
        rd(BASE_DW, 4'hF, v);
        chk("R1", "control dword after reset", {32'h0, v}, 64'h0186_0000);
        check_all("R1");

        // R2 / R7: write all ones, enabled -> count limited to capable
        do_write(BASE_DW, 4'hF, 32'hFFFF_FFFF, "R7");
        rd(BASE_DW, 4'hF, v);
        chk("R2", "control after all-ones write", {32'h0, v}, 64'h01B7_0000);
        // R7: count 7 written while disabled is kept
        do_write(BASE_DW, 4'hF, 32'h0070_0000, "R9");
        rd(BASE_DW, 4'hF, v);
        chk("R7", "count kept while disabled", {32'h0, v}, 64'h01F6_0000);

        // R3: address words
        do_write(BASE_DW + 1, 4'hF, 32'hFFFF_FFFF, "");
        do_write(BASE_DW + 2, 4'hF, 32'hFFFF_FFFF, "");
        rd(BASE_DW + 1, 4'hF, v);
        chk("R3", "low address bits 1:0 zero", {32'h0, v}, 64'hFFFF_FFFC);
        rd(BASE_DW + 2, 4'hF, v);
        chk("R3", "high address writable", {32'h0, v}, 64'hFFFF_FFFF);
        // R4: data word
        do_write(BASE_DW + 3, 4'hF, 32'hFFFF_FFFF, "");
        rd(BASE_DW + 3, 4'hF, v);
        chk("R4", "data upper half zero", {32'h0, v}, 64'h0000_FFFF);
        // R5: mask word limited to N bits
        do_write(BASE_DW + 4, 4'hF, 32'hFFFF_FFFF, "");
        rd(BASE_DW + 4, 4'hF, v);
        chk("R5", "mask writable bits", {32'h0, v}, 64'h0000_00FF);
        // R6: pending read-only to software, driven by set/clear
        do_write(BASE_DW + 5, 4'hF, 32'hFFFF_FFFF, "");
        rd(BASE_DW + 5, 4'hF, v);
        chk("R6", "pending ignores writes", {32'h0, v}, 64'h0);
        do_pend(8'hFF, 8'h00);
        do_pend(8'h00, 8'h0F);
        rd(BASE_DW + 5, 4'hF, v);
        chk("R6", "pending after set and clear", {32'h0, v}, 64'h0000_00F0);
        // R8: enable with count 2 (4 vectors) trims pending
        do_pend(8'h0C, 8'h00);
        do_write(BASE_DW, 4'h4, 32'h0021_0000, "R9");
        rd(BASE_DW + 5, 4'hF, v);
        chk("R8", "pending trimmed to 4 vectors", {32'h0, v}, 64'h0000_000C);
        check_all("R8");

        // R10: writes next to the window, lane masks on reads
        do_write(BASE_DW + 6, 4'hF, 32'hFFFF_FFFF, "R10");
        do_write(BASE_DW - 1, 4'hF, 32'h0000_0000, "R10");
        rd(BASE_DW + 6, 4'hF, v);
        chk("R10", "read beyond window", {32'h0, v}, 64'h0);
        rd(BASE_DW + 1, 4'h1, v);
        chk("R10", "single-lane read", {32'h0, v}, 64'h0000_00FC);
        rd(BASE_DW, 4'h3, v);
        chk("R10", "id and pointer bytes", {32'h0, v}, 64'h0);
        @(negedge clk);
        cfg_addr = 6'(BASE_DW + 1); cfg_be = 4'hF; cfg_rd = 1'b0;
        #1 chk("R10", "no read request", {32'h0, cfg_rdata}, 64'h0);
        check_all("R10");

        // Random mix
        for (int i = 0; i < 300; i++) begin
            int op = $urandom % 4;
            if (op == 3) begin
                do_pend(8'($urandom), 8'($urandom));
            end else begin
                do_write(BASE_DW - 1 + int'($urandom % 8), 4'($urandom), $urandom, "");
            end
            check_all("R2");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule